// File: doc/BRIEF.md
# Cache Residency Length Monitor

This block watches a stream of memory reference addresses and mirrors the tag state of a small direct-mapped cache. For every line it keeps a valid bit, the resident tag and a count of the references that line has served since its block was placed there. It stores no data. Its only purpose is to measure how long each residency lasts, counted in references served.

A residency ends when a different block maps to the same line. The block then issues a one-cycle report carrying the finished length. A flush request ends every open residency. The lines are reported one per cycle in ascending index order, and afterwards every line is empty. The resulting stream of lengths feeds whatever statistics logic sits downstream.

Top module: `residency_monitor`

## Requirements
- R1: After reset, `repValid` and `flushBusy` are low and every line is invalid, so the first reference to any line produces no report.
- R2: A line is selected by address bits [OFF+IDX-1:OFF], where OFF = log2(LINE_BYTES) and IDX = log2(NUM_LINES). The tag is the bits above them, and the offset bits below OFF are ignored. With the defaults, the index is bits [4:2] and the tag is bits [15:5].
- R3: A reference to an invalid line makes it valid with the new tag and a count of 1, and produces no report.
- R4: A reference whose tag matches a valid line adds one to that line's count and produces no report.
- R5: A reference whose tag differs from a valid line's tag raises `repValid` in the following cycle, with `repLen` equal to the old count. The line then holds the new tag with a count of 1.
- R6: When the same block returns after an eviction, it starts a new residency, and each of its residencies is reported on its own.
- R7: The count saturates at 2^CNT_W-1 and does not wrap.
- R8: A pulse on `flushReq` while idle raises `flushBusy` in the next cycle. The drain then visits the lines in ascending index order, one per cycle. Each valid line reports its count and is cleared, and invalid lines are skipped silently. `flushBusy` falls after the last line has been visited.
- R9: In any cycle that carries a reference, the drain pauses. An eviction report caused by that reference goes out first, and the drain resumes in the next cycle without a reference.
- R10: `repValid` is a single-cycle pulse per residency, and is asserted only in the cycle after a reference or a drain step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | A reference is present this cycle |
| refAddr | input | ADDR_W | Byte address of the reference |
| flushReq | input | 1 | Start draining all open residencies |
| repValid | output | 1 | Residency length report strobe |
| repLen | output | CNT_W | Finished residency length |
| flushBusy | output | 1 | Flush drain in progress |

## Verification
The hardest case to reach is a conflicting reference that lands during a flush drain. In that cycle, an eviction report and a drain step both compete for the single report output. The bench fills two lines and starts a flush. On the very next cycle it drives a conflicting reference to line 0, before the drain has touched that line. It then checks that the eviction length appears first, followed by the drained lengths in index order, with the pause keeping the stream free of gaps. Saturation is reached by holding one line for 300 consecutive hits.

// File: rtl/residency_pkg.sv
package residency_pkg;
  typedef struct packed {
    logic lookup;
    logic drain;
  } ctrlStrobe_t;
endpackage

// File: rtl/residency_ctrl.sv
module residency_ctrl #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic clk,
  input  logic rstN,
  input  logic refValid,
  input  logic flushReq,
  output residency_pkg::ctrlStrobe_t strobe,
  output logic [IDX_W-1:0] drainIdx,
  output logic flushBusy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);
  logic busyQ;
  logic [IDX_W-1:0] ptrQ;

  always_comb begin
    strobe.lookup = refValid;
    strobe.drain  = busyQ && !refValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      ptrQ  <= '0;
    end else if (!busyQ) begin
      if (flushReq) begin
        busyQ <= 1'b1;
        ptrQ  <= '0;
      end
    end else if (strobe.drain) begin
      if (ptrQ == LAST_IDX) busyQ <= 1'b0;
      else ptrQ <= ptrQ + 1'b1;
    end
  end

  assign drainIdx  = ptrQ;
  assign flushBusy = busyQ;
endmodule

// File: rtl/residency_datapath.sv
module residency_datapath #(
  parameter int NUM_LINES  = 8,
  parameter int LINE_BYTES = 4,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 8,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic clk,
  input  logic rstN,
  input  residency_pkg::ctrlStrobe_t strobe,
  input  logic [ADDR_W-1:0] refAddr,
  input  logic [IDX_W-1:0] drainIdx,
  output logic repValid,
  output logic [CNT_W-1:0] repLen
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [NUM_LINES-1:0] validQ;
  logic [TAG_W-1:0] tagQ [NUM_LINES];
  logic [CNT_W-1:0] cntQ [NUM_LINES];
  logic repValidQ;
  logic [CNT_W-1:0] repLenQ;

  logic [IDX_W-1:0] refIdx;
  logic [TAG_W-1:0] refTag;
  logic hit;

  always_comb begin
    refIdx = refAddr[OFF_W +: IDX_W];
    refTag = refAddr[ADDR_W-1 -: TAG_W];
    hit    = validQ[refIdx] && (tagQ[refIdx] == refTag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ    <= '0;
      repValidQ <= 1'b0;
      repLenQ   <= '0;
    end else begin
      repValidQ <= 1'b0;
      if (strobe.lookup) begin
        if (hit) begin
          if (cntQ[refIdx] != CNT_MAX) cntQ[refIdx] <= cntQ[refIdx] + 1'b1;
        end else begin
          if (validQ[refIdx]) begin
            repValidQ <= 1'b1;
            repLenQ   <= cntQ[refIdx];
          end
          validQ[refIdx] <= 1'b1;
          tagQ[refIdx]   <= refTag;
          cntQ[refIdx]   <= CNT_ONE;
        end
      end else if (strobe.drain && validQ[drainIdx]) begin
        repValidQ        <= 1'b1;
        repLenQ          <= cntQ[drainIdx];
        validQ[drainIdx] <= 1'b0;
      end
    end
  end

  assign repValid = repValidQ;
  assign repLen   = repLenQ;
endmodule

// File: rtl/residency_monitor.sv
module residency_monitor #(
  parameter int NUM_LINES  = 8,
  parameter int LINE_BYTES = 4,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic clk,
  input  logic rstN,
  input  logic refValid,
  input  logic [ADDR_W-1:0] refAddr,
  input  logic flushReq,
  output logic repValid,
  output logic [CNT_W-1:0] repLen,
  output logic flushBusy
);
  residency_pkg::ctrlStrobe_t strobe;
  logic [IDX_W-1:0] drainIdx;

  residency_ctrl #(.NUM_LINES(NUM_LINES)) uCtrl (
    .clk(clk), .rstN(rstN), .refValid(refValid), .flushReq(flushReq),
    .strobe(strobe), .drainIdx(drainIdx), .flushBusy(flushBusy)
  );

  residency_datapath #(
    .NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .refAddr(refAddr),
    .drainIdx(drainIdx), .repValid(repValid), .repLen(repLen)
  );
endmodule

// File: rtl/residency_monitor_chk.sv
module residency_monitor_chk #(
  parameter int CNT_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic refValid,
  input logic flushReq,
  input logic repValid,
  input logic [CNT_W-1:0] repLen,
  input logic flushBusy
);
  // R5: every finished residency served at least one reference
  assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    repValid |-> repLen != '0);
  // R8: an idle flush request starts the drain
  assert_flush_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    flushReq && !flushBusy |=> flushBusy);
  // R8: the drain only begins after a request
  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flushBusy) |-> $past(flushReq));
  // R10: a report follows a reference or a drain step
  assert_report_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    repValid |-> ($past(refValid) || $past(flushBusy)));
endmodule

bind residency_monitor residency_monitor_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .refValid(refValid), .flushReq(flushReq),
  .repValid(repValid), .repLen(repLen), .flushBusy(flushBusy)
);

// File: tb/tb_residency_monitor.sv
module tb_residency_monitor;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refValid = 1'b0;
  logic [ADDR_W-1:0] refAddr = '0;
  logic flushReq = 1'b0;
  logic repValid;
  logic [CNT_W-1:0] repLen;
  logic flushBusy;

  int testsRun = 0;
  int testsFailed = 0;
  int reps[$];

  always #10 clk = ~clk;

  residency_monitor dut (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refAddr(refAddr),
    .flushReq(flushReq), .repValid(repValid), .repLen(repLen), .flushBusy(flushBusy)
  );

  // address = tag*32 + index*4 + byte offset (index bits [4:2])
  function automatic logic [ADDR_W-1:0] mk(int tag, int idx, int off);
    return ADDR_W'(tag * 32 + idx * 4 + off);
  endfunction

  // vector table: tag, index, offset, expected report valid, expected length
  localparam int NV = 9;
  localparam int V_TAG [NV] = '{0, 0, 0, 1, 1, 0, 0, 2, 0};
  localparam int V_IDX [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0};
  localparam int V_OFF [NV] = '{0, 1, 3, 0, 2, 0, 0, 0, 1};
  localparam int V_RV  [NV] = '{0, 0, 0, 1, 0, 1, 0, 1, 0};
  localparam int V_LEN [NV] = '{0, 0, 0, 3, 0, 2, 0, 1, 0};

  task automatic check(string req, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic refStep(logic [ADDR_W-1:0] a);
    refValid = 1'b1; refAddr = a;
    @(negedge clk);
    refValid = 1'b0;
  endtask

  task automatic collect(int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (repValid) reps.push_back(int'(repLen));
    end
  endtask

  initial begin
    #3_000_000;
    testsRun++; testsFailed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 repValid", int'(repValid), 0);
    check("R1 flushBusy", int'(flushBusy), 0);

    // R2 R3 R4 R5 R6 via vector table
    for (int i = 0; i < NV; i++) begin
      refStep(mk(V_TAG[i], V_IDX[i], V_OFF[i]));
      check($sformatf("R5 vec%0d valid", i), int'(repValid), V_RV[i]);
      if (V_RV[i] != 0) check($sformatf("R6 vec%0d len", i), int'(repLen), V_LEN[i]);
    end
    // R10: pulse only one cycle
    refStep(mk(1, 1, 0));
    check("R10 conflict report", int'(repValid), 1);
    @(negedge clk);
    check("R10 pulse width", int'(repValid), 0);
    // line0 tag0 cnt2, line1 tag1 cnt1

    // R8 flush drain
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    check("R8 busy after request", int'(flushBusy), 1);
    reps.delete();
    collect(10);
    check("R8 report count", reps.size(), 2);
    if (reps.size() == 2) begin
      check("R8 first line", reps[0], 2);
      check("R8 second line", reps[1], 1);
    end
    check("R8 busy cleared", int'(flushBusy), 0);
    refStep(mk(0, 0, 0));
    check("R8 line empty after flush", int'(repValid), 0);

    // R7 saturation on line 3
    refStep(mk(0, 3, 0));
    for (int k = 0; k < 299; k++) refStep(mk(0, 3, k % 4));
    refStep(mk(1, 3, 0));
    check("R7 saturated valid", int'(repValid), 1);
    check("R7 saturated len", int'(repLen), 255);

    // R9 eviction during drain; line0 tag0 cnt1 (from R8 check), line3 tag1 cnt1
    refStep(mk(0, 2, 0));
    refStep(mk(0, 2, 0));
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    refStep(mk(1, 0, 0));
    check("R9 eviction first", int'(repValid), 1);
    check("R9 eviction len", int'(repLen), 1);
    reps.delete();
    collect(12);
    check("R9 drained count", reps.size(), 3);
    if (reps.size() == 3) begin
      check("R9 line0 new residency", reps[0], 1);
      check("R9 line2", reps[1], 2);
      check("R9 line3", reps[2], 1);
    end

    // R1 reset clears state
    refStep(mk(0, 5, 0));
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    refStep(mk(3, 5, 0));
    check("R1 invalid after reset", int'(repValid), 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule